// File: doc/BRIEF.md
# Region-Policy Fill Cache Controller

This controller sits between a fast processor core and a slow legacy system bus with a 16-bit byte address. The address space is split into eight equal regions, and each region has a fixed policy. Some regions are backed by onboard RAM. Some always go out to the external bus. Two regions hold read-only code that is copied into onboard memory on first use and served locally after that.

One of the two read-only regions is a cartridge window whose contents change when software writes to it. Such a write is forwarded to the bus, and the region's local copy is discarded.

An 8-bit configuration mask holds one enable bit per region. A cleared bit forces every access to that region onto the external bus. Changing a bit drops that region's local copy.

The processor side is a valid/ready request stream with a one-cycle response pulse. A request must be held, unchanged, until the cycle in which `cpu_ready` is high. Back-pressure arises in three cases:
- while an external transaction is in flight;
- while a region fill is running and the request targets that region or needs the bus;
- in the one cycle in which a filled word is written into onboard memory.

Top module: `region_fill_cache`

## Requirements
- R1: The region index is address bits [ADDR_W-1:ADDR_W-3]. Regions 1, 5, 6 and 7 are onboard RAM. Regions 2 and 4 are external only. Regions 0 and 3 are cacheable read-only regions, and region 3 is the cartridge window.
- R2: With its mask bit set, an access to a RAM region is served from onboard memory with no external cycle. `cpu_rvalid` rises in the cycle after acceptance, carrying the onboard read data for reads.
- R3: Every access to regions 2 and 4 produces exactly one external transaction. The response comes in the cycle after `ext_ack`, with the value of `ext_rdata` that was present at the acknowledge.
- R4: A read that misses in a cacheable region is completed first as a single external read. The controller then copies the whole region word by word in ascending address order, with external reads followed by onboard writes. After the copy, reads anywhere in the region are served locally with no external cycle.
- R5: While a fill runs, `cpu_ready` stays low for requests to the region being filled and for any request that needs the external bus. Local requests to other regions are still accepted.
- R6: A write to region 3 is forwarded to the external bus and clears region 3's valid flag. The next read there misses and refills from the bus.
- R7: A write to region 0 goes to the external bus only. It never writes onboard memory, and a later read returns the previously cached word.
- R8: When a region's mask bit is 0, every access to that region is an external transaction, whatever the region's policy.
- R9: Any change of a region's mask bit clears that region's valid flag. Once the bit is set again, the next read in the region misses and refills.
- R10: After reset, all valid flags are clear, `ext_req` is low and `cpu_rvalid` is low.
- R11: `ext_req`, `ext_addr` and `ext_we` stay stable from the cycle `ext_req` rises until the cycle `ext_ack` is seen. Only one external transaction is ever outstanding.
- R12: Each accepted request yields exactly one single-cycle `cpu_rvalid` pulse, for writes as well as reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask | input | 8 | Per-region enable; bit n covers region n |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request accepted this cycle when high with cpu_valid |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_we | input | 1 | Request is a write |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rvalid | output | 1 | Response pulse, one per accepted request |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_rvalid |
| ext_req | output | 1 | External transaction request, held until acknowledge |
| ext_addr | output | ADDR_W | External byte address |
| ext_we | output | 1 | External write |
| ext_wdata | output | DATA_W | External write data |
| ext_ack | input | 1 | One-cycle acknowledge of the pending transaction |
| ext_rdata | input | DATA_W | External read data, valid with ext_ack |
| mem_en | output | 1 | Onboard memory access enable |
| mem_we | output | 1 | Onboard memory write |
| mem_addr | output | ADDR_W-1 | Onboard word address |
| mem_wdata | output | DATA_W | Onboard write data |
| mem_rdata | input | DATA_W | Onboard read data, one cycle after mem_en |

## Verification
The assertions assume a well-behaved environment on three points:
- `ext_ack` is a single-cycle pulse that occurs only while `ext_req` is high.
- The processor holds a request stable until it is accepted.
- Onboard memory returns read data exactly one cycle after `mem_en`.

The bench's bus model acknowledges once, one cycle after it sees a request, and then waits for a new one. The bench's memory model is a synchronous one-cycle RAM. Requests are driven on the falling edge and released only after an accepting rising edge. Mask changes are applied between requests, and the bench lets the bus go quiet after each miss before it counts external cycles for the next vector.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int REGION_BITS = 3;
  localparam int NUM_REGIONS = 1 << REGION_BITS;
  localparam logic [REGION_BITS-1:0] CART_REGION = 3'd3;

  typedef enum logic [1:0] {POL_RAM, POL_ROM, POL_EXT} pol_e;
  typedef enum logic [1:0] {ACC_LOCAL, ACC_EXT, ACC_MISS} acc_e;

  function automatic pol_e region_policy(input logic [REGION_BITS-1:0] r);
    case (r)
      3'd0, 3'd3: return POL_ROM;
      3'd2, 3'd4: return POL_EXT;
      default:    return POL_RAM;
    endcase
  endfunction
endpackage

// File: rtl/rfc_policy.sv
module rfc_policy
  import rfc_pkg::*;
(
  input  logic [REGION_BITS-1:0] region,
  input  logic                   we,
  input  logic [NUM_REGIONS-1:0] mask,
  input  logic [NUM_REGIONS-1:0] valid,
  output acc_e                   acc
);
  pol_e pol;

  always_comb begin
    pol = region_policy(region);
    if (!mask[region]) begin
      acc = ACC_EXT;
    end else begin
      case (pol)
        POL_RAM: acc = ACC_LOCAL;
        POL_EXT: acc = ACC_EXT;
        default: acc = we ? ACC_EXT : (valid[region] ? ACC_LOCAL : ACC_MISS);
      endcase
    end
  end
endmodule

// File: rtl/rfc_flags.sv
module rfc_flags
  import rfc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REGIONS-1:0] mask,
  input  logic                   clr_en,
  input  logic [REGION_BITS-1:0] clr_idx,
  input  logic                   fill_start,
  input  logic [REGION_BITS-1:0] start_idx,
  input  logic                   fill_busy,
  input  logic [REGION_BITS-1:0] fill_idx,
  input  logic                   fill_done,
  output logic [NUM_REGIONS-1:0] valid
);
  logic [NUM_REGIONS-1:0] mask_q;
  logic [NUM_REGIONS-1:0] clr_vec;
  logic                   tainted;
  logic                   set_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask;
  end

  // a clear landing on the region under fill spoils that fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            tainted <= 1'b0;
    else if (fill_start)                   tainted <= clr_vec[start_idx];
    else if (fill_busy && clr_vec[fill_idx]) tainted <= 1'b1;
  end

  assign set_en = fill_done && !tainted;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign clr_vec[g] = (mask[g] ^ mask_q[g]) ||
                        (clr_en && (clr_idx == REGION_BITS'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      valid[g] <= 1'b0;
      else if (clr_vec[g])                             valid[g] <= 1'b0;
      else if (set_en && (fill_idx == REGION_BITS'(g))) valid[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/rfc_fill.sv
module rfc_fill
  import rfc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [REGION_BITS-1:0] start_region,
  input  logic                   ext_ack,
  input  logic [DATA_W-1:0]      ext_rdata,
  output logic                   busy,
  output logic [REGION_BITS-1:0] region,
  output logic                   done,
  output logic                   ext_req,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic                   mem_we,
  output logic [ADDR_W-2:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata
);
  localparam int OFF_W = ADDR_W - REGION_BITS - 1;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WR} fst_e;
  fst_e             state;
  logic [OFF_W-1:0] idx;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= F_IDLE;
      idx    <= '0;
      region <= '0;
      data_q <= '0;
    end else begin
      case (state)
        F_IDLE: if (start) begin
          state  <= F_REQ;
          idx    <= '0;
          region <= start_region;
        end
        F_REQ: if (ext_ack) begin
          data_q <= ext_rdata;
          state  <= F_WR;
        end
        default: begin
          if (idx == '1) state <= F_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= F_REQ;
          end
        end
      endcase
    end
  end

  assign busy      = (state != F_IDLE);
  assign ext_req   = (state == F_REQ);
  assign ext_addr  = {region, idx, 1'b0};
  assign mem_we    = (state == F_WR);
  assign mem_addr  = {region, idx};
  assign mem_wdata = data_q;
  assign done      = (state == F_WR) && (idx == '1);
endmodule

// File: rtl/region_fill_cache.sv
module region_fill_cache
  import rfc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REGIONS-1:0] cfg_mask,
  input  logic                   cpu_valid,
  output logic                   cpu_ready,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic                   cpu_we,
  input  logic [DATA_W-1:0]      cpu_wdata,
  output logic                   cpu_rvalid,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   ext_req,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic                   ext_we,
  output logic [DATA_W-1:0]      ext_wdata,
  input  logic                   ext_ack,
  input  logic [DATA_W-1:0]      ext_rdata,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [ADDR_W-2:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata
);
  localparam int WA_W = ADDR_W - 1;

  typedef enum logic {C_IDLE, C_EXT} cst_e;

  logic [REGION_BITS-1:0] req_region;
  acc_e                   acc;
  logic [NUM_REGIONS-1:0] valid;
  cst_e                   cstate;
  logic                   resp_v, resp_local, xmiss, xwe;
  logic [ADDR_W-1:0]      xaddr;
  logic [DATA_W-1:0]      xwdata, xdata;
  logic                   accept, go_local, go_ext, cart_clr, in_fill_region;
  logic                   fill_start, fill_busy, fill_done, fill_ext_req, fill_mem_we;
  logic [REGION_BITS-1:0] fill_region;
  logic [ADDR_W-1:0]      fill_ext_addr;
  logic [WA_W-1:0]        fill_mem_addr;
  logic [DATA_W-1:0]      fill_mem_wdata;

  assign req_region = cpu_addr[ADDR_W-1 -: REGION_BITS];

  rfc_policy u_policy (
    .region (req_region),
    .we     (cpu_we),
    .mask   (cfg_mask),
    .valid  (valid),
    .acc    (acc)
  );

  rfc_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask       (cfg_mask),
    .clr_en     (cart_clr),
    .clr_idx    (req_region),
    .fill_start (fill_start),
    .start_idx  (xaddr[ADDR_W-1 -: REGION_BITS]),
    .fill_busy  (fill_busy),
    .fill_idx   (fill_region),
    .fill_done  (fill_done),
    .valid      (valid)
  );

  rfc_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (fill_start),
    .start_region (xaddr[ADDR_W-1 -: REGION_BITS]),
    .ext_ack      (ext_ack && fill_busy),
    .ext_rdata    (ext_rdata),
    .busy         (fill_busy),
    .region       (fill_region),
    .done         (fill_done),
    .ext_req      (fill_ext_req),
    .ext_addr     (fill_ext_addr),
    .mem_we       (fill_mem_we),
    .mem_addr     (fill_mem_addr),
    .mem_wdata    (fill_mem_wdata)
  );

  // acceptance: local work avoids the region under fill and the fill write slot,
  // bus work waits for the fill to release the external port
  always_comb begin
    in_fill_region = fill_busy && (req_region == fill_region);
    if (cstate != C_IDLE)      cpu_ready = 1'b0;
    else if (acc == ACC_LOCAL) cpu_ready = !in_fill_region && !fill_mem_we;
    else                       cpu_ready = !fill_busy;
    accept     = cpu_valid && cpu_ready;
    go_local   = accept && (acc == ACC_LOCAL);
    go_ext     = accept && (acc != ACC_LOCAL);
    cart_clr   = accept && cpu_we && (req_region == CART_REGION);
    fill_start = (cstate == C_EXT) && ext_ack && xmiss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cstate     <= C_IDLE;
      resp_v     <= 1'b0;
      resp_local <= 1'b0;
      xmiss      <= 1'b0;
      xwe        <= 1'b0;
      xaddr      <= '0;
      xwdata     <= '0;
      xdata      <= '0;
    end else begin
      resp_v <= 1'b0;
      case (cstate)
        C_IDLE: begin
          if (go_local) begin
            resp_v     <= 1'b1;
            resp_local <= 1'b1;
          end else if (go_ext) begin
            cstate <= C_EXT;
            xaddr  <= cpu_addr;
            xwe    <= cpu_we;
            xwdata <= cpu_wdata;
            xmiss  <= (acc == ACC_MISS);
          end
        end
        default: begin
          if (ext_ack) begin
            xdata      <= ext_rdata;
            resp_v     <= 1'b1;
            resp_local <= 1'b0;
            cstate     <= C_IDLE;
          end
        end
      endcase
    end
  end

  assign cpu_rvalid = resp_v;
  assign cpu_rdata  = resp_local ? mem_rdata : xdata;

  always_comb begin
    if (fill_mem_we) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = fill_mem_addr;
      mem_wdata = fill_mem_wdata;
    end else begin
      mem_en    = go_local;
      mem_we    = cpu_we;
      mem_addr  = cpu_addr[ADDR_W-1:1];
      mem_wdata = cpu_wdata;
    end
  end

  assign ext_req   = fill_busy ? fill_ext_req  : (cstate == C_EXT);
  assign ext_addr  = fill_busy ? fill_ext_addr : xaddr;
  assign ext_we    = !fill_busy && xwe;
  assign ext_wdata = xwdata;
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk
  import rfc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_REGIONS-1:0] cfg_mask,
  input logic                   cpu_valid,
  input logic                   cpu_ready,
  input logic [ADDR_W-1:0]      cpu_addr,
  input logic                   cpu_we,
  input logic                   cpu_rvalid,
  input logic                   ext_req,
  input logic                   ext_ack,
  input logic [ADDR_W-1:0]      ext_addr,
  input logic                   ext_we,
  input logic                   mem_en,
  input logic                   mem_we,
  input logic                   fill_busy,
  input logic [REGION_BITS-1:0] fill_region
);
  logic [REGION_BITS-1:0] rg;
  logic                   acc_now;
  assign rg      = cpu_addr[ADDR_W-1 -: REGION_BITS];
  assign acc_now = cpu_valid && cpu_ready;

  // R2: enabled RAM region is served by the onboard memory in the accept cycle
  a_r2_ram_local: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now && cfg_mask[rg] && (region_policy(rg) == POL_RAM) |-> mem_en);

  // R3: peripheral and I/O regions always raise a bus request
  a_r3_io_external: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now && (region_policy(rg) == POL_EXT) |=> ext_req);

  // R5: the region under fill is never accepted
  a_r5_fill_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy && (rg == fill_region) |-> !cpu_ready);

  // R7: read-only region writes never touch onboard memory
  a_r7_rom_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now && cpu_we && (region_policy(rg) == POL_ROM) |-> !(mem_en && mem_we));

  // R8: disabled region goes to the bus
  a_r8_mask_off_external: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now && !cfg_mask[rg] |=> ext_req);

  // R11: pending bus request holds its fields
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we));

  // R12: an accepted request is answered next cycle or has gone to the bus
  a_r12_accept_progress: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now |=> (cpu_rvalid || ext_req));
endmodule

bind region_fill_cache rfc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mask    (cfg_mask),
  .cpu_valid   (cpu_valid),
  .cpu_ready   (cpu_ready),
  .cpu_addr    (cpu_addr),
  .cpu_we      (cpu_we),
  .cpu_rvalid  (cpu_rvalid),
  .ext_req     (ext_req),
  .ext_ack     (ext_ack),
  .ext_addr    (ext_addr),
  .ext_we      (ext_we),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .fill_busy   (fill_busy),
  .fill_region (fill_region)
);

// File: tb/region_fill_cache_tb_top.sv
module region_fill_cache_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cfg_mask = 8'hFF;
  logic          cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          ext_req, ext_we;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata;
  logic          ext_ack = 1'b0;
  logic [DW-1:0] ext_rdata = '0;
  logic          mem_en, mem_we;
  logic [AW-2:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0, fails = 0, ext_cnt = 0;
  logic [3:0] bank = 4'h0;
  logic       wcnt = 1'b0;
  logic [DW-1:0] mem [0:(1<<(AW-1))-1];

  region_fill_cache #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] bus_val(input logic [AW-1:0] a, input logic [3:0] b);
    return {(a[AW-1:AW-3] == 3'd3) ? b : 4'h0, a} ^ 16'h3C00;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  // bus model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    ext_ack <= 1'b0;
    if (rst_n && ext_req && !ext_ack) begin
      if (wcnt) begin
        ext_ack   <= 1'b1;
        ext_rdata <= bus_val(ext_addr, bank);
        ext_cnt   <= ext_cnt + 1;
        wcnt      <= 1'b0;
        if (ext_we && ext_addr[AW-1:AW-3] == 3'd3) bank <= ext_wdata[3:0];
      end else wcnt <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int delta);
    int start;
    start = ext_cnt;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_we = w; cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1 cpu_valid = 1'b0;
    @(negedge clk);
    while (!cpu_rvalid) @(negedge clk);
    rd = cpu_rdata;
    delta = ext_cnt - start;
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 8) begin
      @(negedge clk);
      if (ext_req) quiet = 0; else quiet++;
    end
  endtask

  typedef struct packed {
    logic [11:0] addr;
    logic        we;
    logic [15:0] data;
    logic        use_bus;
    logic [3:0]  bank;
    logic [7:0]  delta;
    logic        settle;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{12'h204, 1'b1, 16'h1111, 1'b0, 4'h0, 8'd0, 1'b0, 4'd2},  // R2 RAM write
    '{12'h204, 1'b0, 16'h1111, 1'b0, 4'h0, 8'd0, 1'b0, 4'd2},  // R2 RAM read back
    '{12'hA10, 1'b1, 16'h2222, 1'b0, 4'h0, 8'd0, 1'b0, 4'd1},  // R1 region 5 is RAM
    '{12'hE1E, 1'b1, 16'h3333, 1'b0, 4'h0, 8'd0, 1'b0, 4'd1},  // R1 region 7 is RAM
    '{12'hA10, 1'b0, 16'h2222, 1'b0, 4'h0, 8'd0, 1'b0, 4'd1},  // R1
    '{12'hE1E, 1'b0, 16'h3333, 1'b0, 4'h0, 8'd0, 1'b0, 4'd1},  // R1
    '{12'h806, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd1, 1'b0, 4'd3},  // R3 I/O read
    '{12'h400, 1'b1, 16'h0042, 1'b0, 4'h0, 8'd1, 1'b0, 4'd3},  // R3 peripheral write
    '{12'h4F2, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd1, 1'b0, 4'd3},  // R3 peripheral read
    '{12'h010, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd1, 1'b1, 4'd4},  // R4 miss then fill
    '{12'h1FE, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd0, 1'b0, 4'd4},  // R4 last word hit
    '{12'h000, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd0, 1'b0, 4'd4},  // R4 first word hit
    '{12'h010, 1'b1, 16'hBEEF, 1'b0, 4'h0, 8'd1, 1'b0, 4'd7},  // R7 ROM write external
    '{12'h010, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd0, 1'b0, 4'd7},  // R7 cached word kept
    '{12'h602, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd1, 1'b1, 4'd4},  // R4 cartridge miss
    '{12'h7FE, 1'b0, 16'h0000, 1'b1, 4'h0, 8'd0, 1'b0, 4'd4},  // R4 cartridge hit
    '{12'h600, 1'b1, 16'h0005, 1'b0, 4'h0, 8'd1, 1'b0, 4'd6},  // R6 bank switch write
    '{12'h604, 1'b0, 16'h0000, 1'b1, 4'h5, 8'd1, 1'b1, 4'd6},  // R6 refill with new bank
    '{12'h606, 1'b0, 16'h0000, 1'b1, 4'h5, 8'd0, 1'b0, 4'd6},  // R6 hit in new bank
    '{12'h204, 1'b0, 16'h1111, 1'b0, 4'h0, 8'd0, 1'b0, 4'd2}   // R2 RAM unaffected
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int d;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(cpu_rvalid == 1'b0, "R10", {15'd0, cpu_rvalid}, 16'h0);
    chk(ext_req == 1'b0, "R10", {15'd0, ext_req}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R10", {15'd0, cpu_ready}, 16'h1);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].addr, VECS[i].we, VECS[i].data, rd, d);
      if (!VECS[i].we)
        chk(rd == (VECS[i].use_bus ? bus_val(VECS[i].addr, VECS[i].bank) : VECS[i].data),
            $sformatf("R%0d data v%0d", VECS[i].req, i), rd,
            VECS[i].use_bus ? bus_val(VECS[i].addr, VECS[i].bank) : VECS[i].data);
      chk(d == int'(VECS[i].delta), $sformatf("R%0d extcount v%0d", VECS[i].req, i),
          16'(d), 16'(VECS[i].delta));
      if (VECS[i].settle) settle();
    end

    // R12 response is a single pulse
    access(12'h204, 1'b0, 16'h0, rd, d);
    @(negedge clk);
    chk(cpu_rvalid == 1'b0, "R12", {15'd0, cpu_rvalid}, 16'h0);

    // R8 masked RAM region goes to the bus
    @(negedge clk); cfg_mask[1] = 1'b0;
    access(12'h204, 1'b0, 16'h0, rd, d);
    chk(rd == bus_val(12'h204, 4'h0), "R8", rd, bus_val(12'h204, 4'h0));
    chk(d == 1, "R8", 16'(d), 16'd1);
    @(negedge clk); cfg_mask[1] = 1'b1;

    // R8 masked ROM region bypasses its valid copy
    @(negedge clk); cfg_mask[0] = 1'b0;
    access(12'h1FE, 1'b0, 16'h0, rd, d);
    chk(d == 1, "R8", 16'(d), 16'd1);
    chk(rd == bus_val(12'h1FE, 4'h0), "R8", rd, bus_val(12'h1FE, 4'h0));

    // R9 re-enable forces a refill
    @(negedge clk); cfg_mask[0] = 1'b1;
    access(12'h020, 1'b0, 16'h0, rd, d);
    chk(d == 1, "R9", 16'(d), 16'd1);
    chk(rd == bus_val(12'h020, 4'h0), "R9", rd, bus_val(12'h020, 4'h0));

    // R5 local work elsewhere proceeds during the fill
    access(12'h206, 1'b1, 16'h5A5A, rd, d);
    access(12'h206, 1'b0, 16'h0, rd, d);
    chk(rd == 16'h5A5A, "R5", rd, 16'h5A5A);

    // R5 the filling region is held off
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = 12'h030; cpu_we = 1'b0;
    #1 chk(cpu_ready == 1'b0, "R5", {15'd0, cpu_ready}, 16'h0);
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1 cpu_valid = 1'b0;
    @(negedge clk);
    while (!cpu_rvalid) @(negedge clk);
    chk(cpu_rdata == bus_val(12'h030, 4'h0), "R5", cpu_rdata, bus_val(12'h030, 4'h0));
    settle();
    access(12'h1F0, 1'b0, 16'h0, rd, d);
    chk(d == 0, "R9", 16'(d), 16'd0);
    chk(rd == bus_val(12'h1F0, 4'h0), "R9", rd, bus_val(12'h1F0, 4'h0));

    // R11 request fields visible while pending
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = 12'h80A; cpu_we = 1'b1; cpu_wdata = 16'h0077;
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1 cpu_valid = 1'b0;
    @(negedge clk);
    chk(ext_req && ext_addr == 12'h80A && ext_we, "R11", {4'h0, ext_addr}, 16'h080A);
    while (!cpu_rvalid) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule